// File: doc/BRIEF.md
# Bus Isolation and Reset Controller

This block governs reset and bus isolation for a peripheral hanging off a host bus that can be fed either by the main bus supply or by an auxiliary supply. It merges every reset source into a single internal reset. That reset asserts at once and releases in step with a free-running local clock. The block also records, during power-on reset, whether the auxiliary supply is present. From that record it derives the power-management capability word.

When the host side powers down, the isolate input goes low. The block then blocks every host bus input, including the bus clock and the bus reset. It tristates every bus output except the wake (power-management event) output. When the isolate input returns high, the bus is powered again, and the block issues a full internal reset of fixed minimum length, timed by the local clock because the bus clock cannot be trusted.

Top module: `bus_iso_rst_ctrl`

## Requirements
- R1: `intRst` is high whenever `porRst` is high. Once every reset source is inactive, `intRst` falls on the second rising clock edge (RST_SYNC_STAGES = 2).
- R2: `auxPwrFlag` takes the value of `auxStrap` on each rising clock edge while `porRst` is high, and keeps that value unchanged while `porRst` is low.
- R3: `pmCap` equals 16'hFE22 when `auxPwrFlag` is 1 and 16'h7E22 when it is 0. Only bit 15 depends on the flag.
- R4: A low level on `altRstN` raises `intRst` without waiting for a clock edge. Release follows the same two-edge rule as R1.
- R5: A low level on `busRstN` while the block is not isolated raises `intRst` at once. Release follows the same two-edge rule as R1.
- R6: `isolateN` passes through two synchronizing flops. On the second rising edge after `isolateN` goes low, `busInBlock` goes to 1 and `busOutEn` goes to all zeros. When not isolated, `busInBlock` is 0 and `busOutEn` equals `busOutEnReq`.
- R7: `wakeOutEn` is 1 at all times, including while isolated.
- R8: While isolated, `busRstN` has no effect on `intRst`.
- R9: When the synchronized `isolateN` rises, an exit reset pulse of EXIT_RST_CYCLES (16) local cycles starts on the third rising edge after `isolateN` rose. `intRst` is high from that edge for EXIT_RST_CYCLES + 2 cycles in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local clock |
| porRst | input | 1 | Internal power-on reset, active high |
| altRstN | input | 1 | Alternate reset, active low |
| isolateN | input | 1 | Isolate request tied to host bus reset, active low, asynchronous |
| busRstN | input | 1 | Host bus reset, active low |
| auxStrap | input | 1 | Auxiliary-power strap (high = auxiliary supply) |
| busOutEnReq | input | NUM_BUS_OUT | Output-enable requests from the bus engine |
| intRst | output | 1 | Combined internal reset, active high |
| auxPwrFlag | output | 1 | Latched auxiliary-power flag |
| pmCap | output | 16 | Power-management capability value |
| busInBlock | output | 1 | 1 = gate off all host bus inputs, clock and reset included |
| busOutEn | output | NUM_BUS_OUT | Per-output tristate enables, 1 = drive |
| wakeOutEn | output | 1 | Enable for the wake event output |

## Verification
The embedded assertions check the following on every cycle:
- the strap flag is held after power-on reset;
- the alternate and bus resets force `intRst` whenever they are visible;
- input gating follows `isolateN` exactly two edges late;
- each exit pulse stays high for at least EXIT_RST_CYCLES cycles;
- `intRst` releases only after the raw reset has been low for an edge.

The directed scenarios show what no single-cycle property captures:
- the exact capability values for both strap settings;
- that a bus reset during isolation leaves `intRst` low;
- the exact edge on which the exit reset starts and its total length through the synchronizer.

// File: rtl/bir_pkg.sv
package bir_pkg;

  // Strobes from the isolation control to the reset/gating datapath
  typedef struct packed {
    logic isolated;   // synchronized isolate level, 1 = bus side off
    logic exitPulse;  // isolate-exit reset pulse, local clock domain
  } ctlStrobe_t;

  localparam logic [15:0] PM_CAP_MAIN    = 16'h7E22;
  localparam int          PM_CAP_AUX_BIT = 15;

endpackage

// File: rtl/bir_ctrl.sv
module bir_ctrl
  import bir_pkg::*;
#(
  parameter int EXIT_RST_CYCLES = 16,
  parameter int ISO_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porRst,
  input  logic       isolateN,
  output ctlStrobe_t ctl
);

  localparam int CNT_W = $clog2(EXIT_RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_RST_CYCLES);

  logic [ISO_SYNC_STAGES-1:0] isoSync;
  logic                       isoSyncOut;
  logic                       isoPrev;
  logic                       exitEdge;
  logic [CNT_W-1:0]           exitCnt;

  // Two-flop (parameterized) synchronizer on the asynchronous isolate pin
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      isoSync <= '1;
    end else begin
      isoSync <= {isoSync[ISO_SYNC_STAGES-2:0], isolateN};
    end
  end

  assign isoSyncOut = isoSync[ISO_SYNC_STAGES-1];

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      isoPrev <= 1'b1;
    end else begin
      isoPrev <= isoSyncOut;
    end
  end

  assign exitEdge = isoSyncOut & ~isoPrev;

  // Exit reset timer on the local clock; a new edge reloads it
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      exitCnt <= '0;
    end else if (exitEdge) begin
      exitCnt <= CNT_LOAD;
    end else if (exitCnt != '0) begin
      exitCnt <= exitCnt - 1'b1;
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.isolated  = ~isoSyncOut;
    ctl.exitPulse = (exitCnt != '0);
  end

  // Checker counter: length of the current exit pulse run
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      runLen <= '0;
    end else if (ctl.exitPulse) begin
      if (runLen != {(CNT_W+1){1'b1}}) runLen <= runLen + 1'b1;
    end else begin
      runLen <= '0;
    end
  end

  // R9: a rising synchronized isolate starts the exit pulse on the next edge
  a_r9_exit_starts: assert property (@(posedge clk) disable iff (porRst)
    $rose(isoSyncOut) |=> ctl.exitPulse);

  // R9: every exit pulse lasts at least EXIT_RST_CYCLES cycles
  a_r9_pulse_len: assert property (@(posedge clk) disable iff (porRst)
    $fell(ctl.exitPulse) |-> (runLen >= (CNT_W+1)'(EXIT_RST_CYCLES)));

endmodule

// File: rtl/bir_rst_sync.sv
module bir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rawRst,
  output logic syncRst
);

  logic [STAGES-1:0] stage;

  // Asynchronous assertion, release shifted through STAGES flops
  always_ff @(posedge clk or posedge rawRst) begin
    if (rawRst) begin
      stage <= '1;
    end else begin
      stage <= {stage[STAGES-2:0], 1'b0};
    end
  end

  assign syncRst = stage[STAGES-1];

  // R1: release only after the raw reset was low at the previous edge
  a_r1_sync_release: assert property (@(posedge clk) disable iff (rawRst)
    $fell(syncRst) |-> !$past(rawRst));

endmodule

// File: rtl/bir_datapath.sv
module bir_datapath
  import bir_pkg::*;
#(
  parameter int NUM_BUS_OUT     = 8,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   porRst,
  input  logic                   altRstN,
  input  logic                   busRstN,
  input  logic                   auxStrap,
  input  logic [NUM_BUS_OUT-1:0] busOutEnReq,
  input  ctlStrobe_t             ctl,
  output logic                   intRst,
  output logic                   auxPwrFlag,
  output logic [15:0]            pmCap,
  output logic                   busInBlock,
  output logic [NUM_BUS_OUT-1:0] busOutEn,
  output logic                   wakeOutEn
);

  logic rawRst;
  logic busRstSeen;

  // Bus reset counts only while the bus side is connected
  assign busRstSeen = ~busRstN & ~ctl.isolated;
  assign rawRst     = porRst | ~altRstN | busRstSeen | ctl.exitPulse;

  bir_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rstSync (
    .clk     (clk),
    .rawRst  (rawRst),
    .syncRst (intRst)
  );

  // Strap capture during power-on reset only
  always_ff @(posedge clk) begin
    if (porRst) begin
      auxPwrFlag <= auxStrap;
    end
  end

  always_comb begin
    pmCap                 = PM_CAP_MAIN;
    pmCap[PM_CAP_AUX_BIT] = auxPwrFlag;
  end

  // Isolation gating: inputs blocked, outputs tristated, wake stays driven
  assign busInBlock = ctl.isolated;

  for (genvar g = 0; g < NUM_BUS_OUT; g++) begin : g_outEn
    assign busOutEn[g] = busOutEnReq[g] & ~ctl.isolated;
  end

  assign wakeOutEn = 1'b1;

  // R2: the flag holds once power-on reset is over
  a_r2_aux_hold: assert property (@(posedge clk) disable iff (porRst)
    $past(!porRst) |-> $stable(auxPwrFlag));

  // R4: alternate reset forces the internal reset
  a_r4_alt_forces: assert property (@(posedge clk) disable iff (porRst)
    !altRstN |-> intRst);

  // R5: visible bus reset forces the internal reset
  a_r5_bus_forces: assert property (@(posedge clk) disable iff (porRst)
    (!busRstN && !busInBlock) |-> intRst);

  // R6: no bus output is driven while inputs are gated
  a_r6_out_off: assert property (@(posedge clk) disable iff (porRst)
    busInBlock |-> (busOutEn == '0));

endmodule

// File: rtl/bus_iso_rst_ctrl.sv
module bus_iso_rst_ctrl
  import bir_pkg::*;
#(
  parameter int NUM_BUS_OUT     = 8,
  parameter int EXIT_RST_CYCLES = 16,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   porRst,
  input  logic                   altRstN,
  input  logic                   isolateN,
  input  logic                   busRstN,
  input  logic                   auxStrap,
  input  logic [NUM_BUS_OUT-1:0] busOutEnReq,
  output logic                   intRst,
  output logic                   auxPwrFlag,
  output logic [15:0]            pmCap,
  output logic                   busInBlock,
  output logic [NUM_BUS_OUT-1:0] busOutEn,
  output logic                   wakeOutEn
);

  ctlStrobe_t ctl;

  bir_ctrl #(
    .EXIT_RST_CYCLES (EXIT_RST_CYCLES),
    .ISO_SYNC_STAGES (2)
  ) u_ctrl (
    .clk      (clk),
    .porRst   (porRst),
    .isolateN (isolateN),
    .ctl      (ctl)
  );

  bir_datapath #(
    .NUM_BUS_OUT     (NUM_BUS_OUT),
    .RST_SYNC_STAGES (RST_SYNC_STAGES)
  ) u_datapath (
    .clk         (clk),
    .porRst      (porRst),
    .altRstN     (altRstN),
    .busRstN     (busRstN),
    .auxStrap    (auxStrap),
    .busOutEnReq (busOutEnReq),
    .ctl         (ctl),
    .intRst      (intRst),
    .auxPwrFlag  (auxPwrFlag),
    .pmCap       (pmCap),
    .busInBlock  (busInBlock),
    .busOutEn    (busOutEn),
    .wakeOutEn   (wakeOutEn)
  );

  // Edges seen since power-on reset ended, saturating at 3
  logic [1:0] edgesSinceRel;
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      edgesSinceRel <= '0;
    end else if (edgesSinceRel != 2'd3) begin
      edgesSinceRel <= edgesSinceRel + 1'b1;
    end
  end

  // R6: input gating tracks the isolate pin two edges late
  a_r6_gate_latency: assert property (@(posedge clk) disable iff (porRst)
    (edgesSinceRel == 2'd3) |-> (busInBlock == !$past(isolateN, 2)));

endmodule

// File: tb/bus_iso_rst_ctrl_bench.sv
module bus_iso_rst_ctrl_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int NOUT        = 8;
  localparam int EXIT_CYC    = 16;
  localparam int SYNC_STAGES = 2;

  logic            clk = 1'b0;
  logic            porRst, altRstN, isolateN, busRstN, auxStrap;
  logic [NOUT-1:0] busOutEnReq;
  logic            intRst, auxPwrFlag, busInBlock, wakeOutEn;
  logic [15:0]     pmCap;
  logic [NOUT-1:0] busOutEn;

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_iso_rst_ctrl #(
    .NUM_BUS_OUT     (NOUT),
    .EXIT_RST_CYCLES (EXIT_CYC),
    .RST_SYNC_STAGES (SYNC_STAGES)
  ) u_bus_iso_rst_ctrl (
    .clk(clk), .porRst(porRst), .altRstN(altRstN), .isolateN(isolateN),
    .busRstN(busRstN), .auxStrap(auxStrap), .busOutEnReq(busOutEnReq),
    .intRst(intRst), .auxPwrFlag(auxPwrFlag), .pmCap(pmCap),
    .busInBlock(busInBlock), .busOutEn(busOutEn), .wakeOutEn(wakeOutEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_por_aux_set;
    porRst = 1; altRstN = 1; isolateN = 1; busRstN = 1; auxStrap = 1;
    busOutEnReq = '1;
    tick(3);
    check("R1 intRst during POR", intRst, 1);
    check("R2 flag captured high", auxPwrFlag, 1);
    porRst = 0;
    tick(1);
    check("R1 held one edge after release", intRst, 1);
    tick(1);
    check("R1 released on second edge", intRst, 0);
    check("R3 capability with aux", pmCap, 16'hFE22);
    check("R6 not isolated, no gating", busInBlock, 0);
    auxStrap = 0;
    tick(3);
    check("R2 flag held after POR", auxPwrFlag, 1);
  endtask

  task automatic t_por_aux_clear;
    porRst = 1; auxStrap = 0;
    tick(2);
    porRst = 0;
    tick(3);
    check("R2 flag captured low", auxPwrFlag, 0);
    check("R3 capability main power", pmCap, 16'h7E22);
    auxStrap = 1;
    tick(2);
    check("R2 strap ignored after POR", auxPwrFlag, 0);
    check("R3 capability unchanged", pmCap, 16'h7E22);
  endtask

  task automatic t_alt_rst;
    altRstN = 0;
    #1;
    check("R4 async assert", intRst, 1);
    tick(1);
    altRstN = 1;
    tick(1);
    check("R4 held one edge", intRst, 1);
    tick(1);
    check("R4 released", intRst, 0);
  endtask

  task automatic t_bus_rst;
    busRstN = 0;
    #1;
    check("R5 async assert", intRst, 1);
    tick(1);
    busRstN = 1;
    tick(1);
    check("R5 held one edge", intRst, 1);
    tick(1);
    check("R5 released", intRst, 0);
  endtask

  task automatic t_isolate_enter;
    busOutEnReq = 8'hA5;
    tick(1);
    check("R6 enables follow request", busOutEn, 8'hA5);
    isolateN = 0;
    tick(1);
    check("R6 not gated after one edge", busInBlock, 0);
    tick(1);
    check("R6 gated after two edges", busInBlock, 1);
    check("R6 outputs tristated", busOutEn, 0);
    check("R7 wake stays driven", wakeOutEn, 1);
  endtask

  task automatic t_isolated_ignore;
    busRstN = 0;
    tick(4);
    check("R8 bus reset ignored", intRst, 0);
    busRstN = 1;
    tick(1);
    check("R8 still no reset", intRst, 0);
  endtask

  task automatic t_isolate_exit;
    int highCount = 0;
    int firstHigh = -1;
    isolateN = 1;
    tick(1);
    check("R6 still gated one edge after rise", busInBlock, 1);
    tick(1);
    check("R6 gating off two edges after rise", busInBlock, 0);
    check("R6 enables restored", busOutEn, 8'hA5);
    check("R9 no reset before third edge", intRst, 0);
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (intRst) begin
        highCount++;
        if (firstHigh < 0) firstHigh = i;
      end
    end
    check("R9 reset starts third edge", firstHigh, 0);
    check("R9 reset length", highCount, EXIT_CYC + SYNC_STAGES);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      testsRun++;
      testsFail++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    t_por_aux_set();
    t_por_aux_clear();
    t_alt_rst();
    t_bus_rst();
    t_isolate_enter();
    t_isolated_ignore();
    t_isolate_exit();
    tick(2);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule